// File: doc/BRIEF.md
# First and Next Error Logger

This block gathers error strobes from a set of internal sources and files each one in one of two status registers. Every source can raise a fatal strobe or a non-fatal strobe. The first-error register keeps the earliest fatal event and, on its own, the earliest non-fatal event. Each of its fields then stays frozen. The next-error register collects every event of a class that arrives after that class's first-error field already holds something.

Software clears bits by writing ones through a small write port. A select line picks which register the write applies to. Two summary outputs show whether any fatal or any non-fatal bit is set anywhere. Diagnostic code reads both register images to find which source failed first and which failed afterwards. A non-fatal strobe may stand for a correctable or an uncorrectable error; the block treats both the same way.

Top module: `fn_err_log`

## Requirements
- R1: After reset, both register images read zero and both summary flags are low.
- R2: While the fatal field of the first-error register is all zero, the fatal strobes seen on a clock edge are loaded into it. Several strobes on the same edge all set their bits.
- R3: Once the fatal field of the first-error register holds a set bit, it changes only when software clears it. Later fatal strobes set the matching bits of the next-error register instead.
- R4: The non-fatal class is handled on its own, with the same rules as R2 and R3. A non-fatal strobe is loaded into the first-error register whenever that register's non-fatal field is zero, whatever the state of the fatal field.
- R5: Bits in the next-error register are sticky. New events are ORed into the existing contents, and a repeated event changes nothing.
- R6: A write with `wr_sel`=0 clears every first-error bit where `wr_data` has a 1. A write with `wr_sel`=1 does the same for the next-error register. Bits written with 0 are unchanged.
- R7: Each register image uses this layout: fatal field in bits 9:0 (bit i = fatal source i), non-fatal field in bits 20:10 (bit 10+i = non-fatal source i), and reserved bits 24:21. The reserved bits always read zero, and writes to them have no effect.
- R8: A strobe that arrives in the same cycle as a clear of its field is never lost. The choice between the two registers depends on the first-error field as it stood before that edge. A strobe bit wins over a clear of the same bit. After a first-error field has been cleared to zero, the next event of that class is loaded into it again.
- R9: `any_fatal` is high exactly when some fatal bit is set in either register. `any_nonfatal` is high exactly when some non-fatal bit is set in either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fat_evt | input | 10 | Fatal event strobes, one per source |
| nf_evt | input | 11 | Non-fatal event strobes, one per source |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_sel | input | 1 | Write target: 0 first-error, 1 next-error |
| wr_data | input | 25 | Bits to clear, in register layout |
| first_reg | output | 25 | First-error register image |
| next_reg | output | 25 | Next-error register image |
| any_fatal | output | 1 | Some fatal bit set in either register |
| any_nonfatal | output | 1 | Some non-fatal bit set in either register |

## Verification
The hardest cases to reach are the ones where a software clear and a new strobe fall on the same edge. One variant clears the first-error field while it is still occupied. The other clears a next-error bit while that same bit is being struck again. To reach them, the stimulus first loads the first-error field through ordinary strobes, then issues a write and a strobe together in one driven cycle. Both register images are read on the following cycle to see where the strobe landed. A separate sequence clears a first-error field to zero and confirms that the very next strobe of that class is loaded into it again.

// File: rtl/fn_err_log.sv
module fn_err_log #(
  parameter int FAT_W = 10,
  parameter int NF_W  = 11,
  parameter int RSV_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [FAT_W-1:0]             fat_evt,
  input  logic [NF_W-1:0]              nf_evt,
  input  logic                         wr_en,
  input  logic                         wr_sel,
  input  logic [FAT_W+NF_W+RSV_W-1:0]  wr_data,
  output logic [FAT_W+NF_W+RSV_W-1:0]  first_reg,
  output logic [FAT_W+NF_W+RSV_W-1:0]  next_reg,
  output logic                         any_fatal,
  output logic                         any_nonfatal
);
  localparam int REG_W = FAT_W + NF_W + RSV_W;

  logic [FAT_W-1:0] f_fat, n_fat;
  logic [NF_W-1:0]  f_nf,  n_nf;

  wire clr_first = wr_en & ~wr_sel;
  wire clr_next  = wr_en &  wr_sel;

  wire [FAT_W-1:0] ff_clr = clr_first ? wr_data[FAT_W-1:0]          : '0;
  wire [NF_W-1:0]  fn_clr = clr_first ? wr_data[FAT_W +: NF_W]      : '0;
  wire [FAT_W-1:0] nf_clr = clr_next  ? wr_data[FAT_W-1:0]          : '0;
  wire [NF_W-1:0]  nn_clr = clr_next  ? wr_data[FAT_W +: NF_W]      : '0;

  wire fat_armed = ~|f_fat;
  wire nf_armed  = ~|f_nf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_fat <= '0;
      n_fat <= '0;
      f_nf  <= '0;
      n_nf  <= '0;
    end else begin
      f_fat <= fat_armed ? fat_evt : (f_fat & ~ff_clr);
      n_fat <= (n_fat & ~nf_clr) | (fat_armed ? '0 : fat_evt);
      f_nf  <= nf_armed ? nf_evt : (f_nf & ~fn_clr);
      n_nf  <= (n_nf & ~nn_clr) | (nf_armed ? '0 : nf_evt);
    end
  end

  assign first_reg    = {{RSV_W{1'b0}}, f_nf, f_fat};
  assign next_reg     = {{RSV_W{1'b0}}, n_nf, n_fat};
  assign any_fatal    = |{f_fat, n_fat};
  assign any_nonfatal = |{f_nf, n_nf};
endmodule

// File: rtl/fn_err_log_chk.sv
module fn_err_log_chk #(
  parameter int FAT_W = 10,
  parameter int NF_W  = 11,
  parameter int RSV_W = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [FAT_W-1:0]             fat_evt,
  input logic [NF_W-1:0]              nf_evt,
  input logic                         wr_en,
  input logic                         wr_sel,
  input logic [FAT_W+NF_W+RSV_W-1:0]  first_reg,
  input logic [FAT_W+NF_W+RSV_W-1:0]  next_reg
);
  wire [FAT_W-1:0] ff = first_reg[FAT_W-1:0];
  wire [NF_W-1:0]  fn = first_reg[FAT_W +: NF_W];
  wire [FAT_W-1:0] nx = next_reg[FAT_W-1:0];

  // R2
  first_fat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ff == '0) |=> (ff == $past(fat_evt)));

  // R3
  first_fat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ff != '0 && !(wr_en && !wr_sel)) |=> (ff == $past(ff)));

  // R3
  later_fat_routed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ff != '0 && fat_evt != '0) |=> ((nx & $past(fat_evt)) == $past(fat_evt)));

  // R4
  first_nf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == '0) |=> (fn == $past(nf_evt)));

  // R5
  next_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> ((next_reg & $past(next_reg)) == $past(next_reg)));
endmodule

bind fn_err_log fn_err_log_chk #(.FAT_W(FAT_W), .NF_W(NF_W), .RSV_W(RSV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fat_evt(fat_evt), .nf_evt(nf_evt),
  .wr_en(wr_en), .wr_sel(wr_sel), .first_reg(first_reg), .next_reg(next_reg)
);

// File: tb/fn_err_log_bench.sv
`timescale 1ns/1ps
module fn_err_log_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  fat_evt = '0;
  logic [10:0] nf_evt = '0;
  logic        wr_en = 0, wr_sel = 0;
  logic [24:0] wr_data = '0;
  logic [24:0] first_reg, next_reg;
  logic        any_fatal, any_nonfatal;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fn_err_log u_fn_err_log (.*);

  task automatic chk(string req, logic [24:0] act, logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [9:0] f, logic [10:0] n, logic we, logic sel, logic [24:0] d);
    @(negedge clk);
    fat_evt = f; nf_evt = n; wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    fat_evt = '0; nf_evt = '0; wr_en = 0; wr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 first", first_reg, 0);
    chk("R1 next", next_reg, 0);
    chk("R1 flags", {any_fatal, any_nonfatal}, 0);
  endtask

  task automatic t_first_multi();
    step(10'b101, 0, 0, 0, 0);
    chk("R2 first", first_reg, 25'h5);
    chk("R2 next", next_reg, 0);
    chk("R9 flags", {any_fatal, any_nonfatal}, 2'b10);
  endtask

  task automatic t_later();
    step(10'b010, 0, 0, 0, 0);
    chk("R3 first frozen", first_reg, 25'h5);
    chk("R3 next", next_reg, 25'h2);
    step(10'h200, 0, 0, 0, 0);
    chk("R5 accumulate", next_reg, 25'h202);
    step(10'h002, 0, 0, 0, 0);
    chk("R5 repeat", next_reg, 25'h202);
  endtask

  task automatic t_nonfatal();
    step(0, 11'h400, 0, 0, 0);
    chk("R4 first nf", first_reg, 25'h100005);
    chk("R9 nf flag", {any_fatal, any_nonfatal}, 2'b11);
    step(0, 11'h001, 0, 0, 0);
    chk("R4 next nf", next_reg, 25'h000602);
    chk("R4 first nf frozen", first_reg, 25'h100005);
  endtask

  task automatic t_clear();
    step(0, 0, 1, 0, 25'h5);
    chk("R6 clear first fatal", first_reg, 25'h100000);
    chk("R6 next untouched", next_reg, 25'h000602);
    step(0, 0, 1, 0, 25'h1E00000);
    chk("R7 reserved ignored", first_reg, 25'h100000);
    chk("R7 reserved next", next_reg[24:21], 0);
  endtask

  task automatic t_coincide();
    step(10'h008, 0, 0, 0, 0);
    chk("R8 rearm", first_reg, 25'h100008);
    step(10'h010, 0, 1, 0, 25'h8);
    chk("R8 clear+event first", first_reg, 25'h100000);
    chk("R8 clear+event next", next_reg, 25'h000612);
    step(10'h001, 0, 0, 0, 0);
    chk("R8 refill", first_reg, 25'h100001);
    step(10'h040, 0, 1, 1, 25'h3FF);
    chk("R8 next set wins", next_reg, 25'h000440);
  endtask

  task automatic t_flags();
    step(0, 0, 1, 0, 25'h1FFFFFF);
    chk("R9 next still holds", {any_fatal, any_nonfatal}, 2'b11);
    step(0, 0, 1, 1, 25'h1FFFFFF);
    chk("R9 all clear", {any_fatal, any_nonfatal}, 2'b00);
    chk("R6 both zero", first_reg | next_reg, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_first_multi();
    t_later();
    t_nonfatal();
    t_clear();
    t_coincide();
    t_flags();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule